// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

A free-running watchdog for a system-on-chip. A 12-bit down-counter advances on a low-speed timebase through a prescaler that divides by 4 up to 256. When the counter passes zero it requests a system reset. Software keeps the system alive by writing a refresh key to the key register before that happens.

The prescaler and reload settings are guarded by an unlock key, and any other key locks them again. Accepted settings are first held in a shadow register. They reach the counter only after three slow-timebase ticks. During that window a per-setting busy flag in the status register is set.

Once the counter is started by its start key, it cannot be stopped short of a reset. The low-speed clock arrives as a single-cycle enable strobe, `slow_tick`, in the register clock domain.

Top module: `wdt_top`

## Requirements
- R1: After reset the reload register reads 0x0000_0FFF, the prescaler register reads 0, the status register reads 0, `wdt_rst_req` is low and the counter is stopped.
- R2: A write to offset 0x00 presents a key in `bus_wdata[15:0]`. Key 0x5555 unlocks the prescaler and reload registers, and any other key locks them. Offset 0x00 reads as zero.
- R3: While locked, writes to the prescaler register (offset 0x04) and to the reload register (offset 0x08) have no effect on the stored values.
- R4: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1 (status at offset 0x0C). Each flag clears on the third `slow_tick` after the write. At that point the new value governs the counter.
- R5: While its busy flag is set, a read of the prescaler or reload register returns 0.
- R6: Key 0xCCCC starts the counter and loads it with the active reload value. No later key or write stops it, and `wdt_rst_req` stays low while the counter is stopped.
- R7: Key 0xAAAA loads the counter with the active reload value. If it coincides with a counter step, the load wins and no reset is requested.
- R8: Prescaler code k (0 to 6) steps the counter once every 4·2^k ticks, and code 7 steps it once every 256 ticks. No step occurs while the counter is stopped.
- R9: A step taken with the counter at zero reloads it and raises `wdt_rst_req` for exactly one clock on the following edge. With reload value R, requests repeat every (R+1)·divide ticks.
- R10: Prescaler reads carry only bits 2:0, reload reads only bits 11:0, and status only bits 1:0. All other read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle strobe per low-speed clock period |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | One-cycle system reset request |

## Verification
The counter and prescaler phase are hidden. A wrong internal count shows only as a reset request that lands in the wrong cycle. For that reason `wdt_rst_req` is compared against a reference model on every clock, so a slip of one tick shows at the very next expiry. Shadow and busy faults show at the first status or register read after a write. A stuck unlock or run flag shows within one expiry period, as either an ignored setting or a missing or unexpected reset pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned PSC_W = 3;
  localparam int unsigned KEY_W = 16;
  localparam int unsigned PRE_W = 8;

  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START = 16'hCCCC;

  localparam logic [3:0] OFS_KEY = 4'h0;
  localparam logic [3:0] OFS_PSC = 4'h4;
  localparam logic [3:0] OFS_RLD = 4'h8;
  localparam logic [3:0] OFS_STAT = 4'hC;

  // ticks per counter step for a prescaler code
  function automatic logic [PRE_W:0] psc_div(input logic [PSC_W-1:0] code);
    logic [PRE_W:0] d;
    if (code == 3'd7) d = 9'd256;
    else d = 9'd4 << code;
    return d;
  endfunction
endpackage

// File: rtl/wdt_keys.sv
module wdt_keys
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  output logic             unlocked,
  output logic             running,
  output logic             load_req
);
  logic is_unlock, is_start, is_refresh;
  assign is_unlock  = key == KEY_UNLOCK;
  assign is_start   = key == KEY_START;
  assign is_refresh = key == KEY_REFRESH;
  assign load_req   = key_wr && (is_start || is_refresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      running  <= 1'b0;
    end else if (key_wr) begin
      unlocked <= is_unlock;
      if (is_start) running <= 1'b1;
    end
  end

  assert_relock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key != 16'h5555) |=> !unlocked);
  assert_run_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
endmodule

// File: rtl/wdt_cfg_sync.sv
module wdt_cfg_sync #(
  parameter int unsigned W = 12,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int unsigned TICKS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_req,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int unsigned NW = $clog2(TICKS + 1);
  localparam logic [NW-1:0] LAST = NW'(TICKS - 1);

  logic [NW-1:0] n;
  logic          commit;
  assign commit = busy && tick && !wr_req && (n == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST_VAL;
      active <= RST_VAL;
      busy   <= 1'b0;
      n      <= '0;
    end else if (wr_req) begin
      shadow <= wdata;
      busy   <= 1'b1;
      n      <= '0;
    end else if (busy && tick) begin
      if (commit) begin
        active <= shadow;
        busy   <= 1'b0;
        n      <= '0;
      end else begin
        n <= n + 1'b1;
      end
    end
  end

  assert_busy_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (busy && shadow == $past(wdata)));
  assert_active_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_req) |=> $stable(active));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             running,
  input  logic             load_req,
  input  logic [CNT_W-1:0] reload,
  input  logic [PSC_W-1:0] psc_code,
  output logic             step,
  output logic             at_zero,
  output logic             rst_req
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W:0]   lim;
  logic [CNT_W-1:0] cnt;

  assign lim     = psc_div(psc_code) - 9'd1;
  assign step    = running && tick && ({1'b0, pre_cnt} >= lim);
  assign at_zero = cnt == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      cnt     <= '1;
      rst_req <= 1'b0;
    end else begin
      if (running && tick) pre_cnt <= step ? '0 : pre_cnt + 1'b1;
      if (load_req) cnt <= reload;
      else if (step) cnt <= at_zero ? reload : cnt - {{(CNT_W-1){1'b0}}, 1'b1};
      rst_req <= step && at_zero && !load_req;
    end
  end

  assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_no_req_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !rst_req);
  assert_refresh_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (!rst_req && cnt == $past(reload)));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned SYNC_TICKS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_rst_req
);
  logic key_wr, psc_wr, rld_wr;
  logic unlocked, running, load_req;
  logic [PSC_W-1:0] psc_shadow, psc_active;
  logic [CNT_W-1:0] rld_shadow, rld_active;
  logic psc_busy, rld_busy;
  logic step, at_zero;

  assign key_wr = bus_we && bus_addr == OFS_KEY;
  assign psc_wr = bus_we && bus_addr == OFS_PSC && unlocked;
  assign rld_wr = bus_we && bus_addr == OFS_RLD && unlocked;

  wdt_keys u_keys (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key(bus_wdata),
    .unlocked(unlocked), .running(running), .load_req(load_req)
  );

  wdt_cfg_sync #(.W(PSC_W), .RST_VAL('0), .TICKS(SYNC_TICKS)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .wr_req(psc_wr),
    .wdata(bus_wdata[PSC_W-1:0]), .shadow(psc_shadow), .active(psc_active),
    .busy(psc_busy)
  );

  wdt_cfg_sync #(.W(CNT_W), .RST_VAL('1), .TICKS(SYNC_TICKS)) u_rld (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .wr_req(rld_wr),
    .wdata(bus_wdata[CNT_W-1:0]), .shadow(rld_shadow), .active(rld_active),
    .busy(rld_busy)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .running(running),
    .load_req(load_req), .reload(rld_active), .psc_code(psc_active),
    .step(step), .at_zero(at_zero), .rst_req(wdt_rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_PSC:  if (!psc_busy) bus_rdata = {{(32-PSC_W){1'b0}}, psc_shadow};
      OFS_RLD:  if (!rld_busy) bus_rdata = {{(32-CNT_W){1'b0}}, rld_shadow};
      OFS_STAT: bus_rdata = {30'd0, rld_busy, psc_busy};
      default:  bus_rdata = '0;
    endcase
  end

  assert_locked_rld_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'h8 && !unlocked) |=> $stable(rld_shadow));
  assert_locked_psc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 4'h4 && !unlocked) |=> $stable(psc_shadow));
  assert_expiry_needs_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> $past(step && at_zero));
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slow_tick = 1'b0;
  logic bus_we = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [31:0] bus_rdata;
  logic wdt_rst_req;

  int tests = 0, fails = 0, cyc = 0;
  int tick_mode = 1, tick_ph = 0;
  int dut_pulses = 0, mdl_pulses = 0, last_pulse = -1, interval = 0;

  // reference model state
  bit m_unlock, m_run, m_rst, m_pbusy, m_rbusy;
  int m_psh, m_pact, m_rsh, m_ract, m_pn, m_rn, m_pre, m_cnt;

  always #2 clk = ~clk;

  wdt_top dut (.clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_req(wdt_rst_req));

  function automatic int ticks_per_step(int code);
    int d = 4;
    for (int i = 0; i < code && d < 256; i++) d = d * 2;
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_unlock = 0; m_run = 0; m_rst = 0; m_pbusy = 0; m_rbusy = 0;
      m_psh = 0; m_pact = 0; m_rsh = 4095; m_ract = 4095;
      m_pn = 0; m_rn = 0; m_pre = 0; m_cnt = 4095;
    end else begin
      automatic bit kw = bus_we && bus_addr == 4'h0;
      automatic bit ld = kw && (bus_wdata == 16'hAAAA || bus_wdata == 16'hCCCC);
      automatic bit stp = m_run && slow_tick && (m_pre + 1 >= ticks_per_step(m_pact));
      automatic bit pw = bus_we && bus_addr == 4'h4 && m_unlock;
      automatic bit rw = bus_we && bus_addr == 4'h8 && m_unlock;
      m_rst = stp && m_cnt == 0 && !ld;
      if (m_run && slow_tick) m_pre = stp ? 0 : m_pre + 1;
      if (ld) m_cnt = m_ract;
      else if (stp) m_cnt = (m_cnt == 0) ? m_ract : m_cnt - 1;
      if (pw) begin m_psh = bus_wdata & 7; m_pbusy = 1; m_pn = 0; end
      else if (m_pbusy && slow_tick) begin
        m_pn++;
        if (m_pn == 3) begin m_pact = m_psh; m_pbusy = 0; m_pn = 0; end
      end
      if (rw) begin m_rsh = bus_wdata & 12'hFFF; m_rbusy = 1; m_rn = 0; end
      else if (m_rbusy && slow_tick) begin
        m_rn++;
        if (m_rn == 3) begin m_ract = m_rsh; m_rbusy = 0; m_rn = 0; end
      end
      if (kw) begin
        m_unlock = bus_wdata == 16'h5555;
        if (bus_wdata == 16'hCCCC) m_run = 1;
      end
    end
  end

  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // tick generator and per-cycle comparison of the reset request
  always @(negedge clk) begin
    cyc++;
    tick_ph++;
    case (tick_mode)
      1: slow_tick <= 1'b1;
      2: slow_tick <= (tick_ph % 3) == 0;
      default: slow_tick <= 1'b0;
    endcase
    if (rst_n) begin
      check("R9 per-cycle rst_req", wdt_rst_req, m_rst);
      if (wdt_rst_req) begin
        dut_pulses++;
        if (last_pulse >= 0) interval = cyc - last_pulse;
        last_pulse = cyc;
      end
      if (m_rst) mdl_pulses++;
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(string req, logic [3:0] a, longint exp);
    @(negedge clk); #1;
    bus_we = 1'b0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(string req, int exp_int);
    dut_pulses = 0; mdl_pulses = 0; last_pulse = -1; interval = 0;
    idle(exp_int * 3 + 10);
    check(req, interval, exp_int);
    check({req, " count"}, dut_pulses, mdl_pulses);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 reload reset", 4'h8, 32'hFFF);
    rd("R1 prescaler reset", 4'h4, 0);
    rd("R1 status reset", 4'hC, 0);
    check("R1 rst_req low", wdt_rst_req, 0);
    rd("R2 key reads zero", 4'h0, 0);
    // R3 locked writes ignored
    wr(4'h8, 16'h0123);
    wr(4'h4, 16'h0005);
    idle(6);
    rd("R3 reload locked", 4'h8, 32'hFFF);
    rd("R3 prescaler locked", 4'h4, 0);
    rd("R3 status after locked", 4'hC, 0);
    // R4 R5 prescaler update, upper data bits dropped (R10)
    wr(4'h0, 16'h5555);
    wr(4'h4, 16'hFFF8);
    rd("R4 psc busy bit0", 4'hC, 1);
    rd("R5 psc read while busy", 4'h4, 0);
    idle(4);
    rd("R4 psc busy cleared", 4'hC, 0);
    rd("R10 psc field only", 4'h4, 0);
    // reload update
    wr(4'h0, 16'h5555);
    wr(4'h8, 16'hF003);
    rd("R4 rld busy bit1", 4'hC, 2);
    rd("R5 rld read while busy", 4'h8, 0);
    idle(4);
    rd("R4 rld busy cleared", 4'hC, 0);
    rd("R10 rld field only", 4'h8, 3);
    // R2 relock by other key
    wr(4'h0, 16'h5555);
    wr(4'h0, 16'h1234);
    wr(4'h8, 16'h0007);
    idle(5);
    rd("R2 relocked reload", 4'h8, 3);
    // R6 stopped: no requests
    dut_pulses = 0;
    idle(100);
    check("R6 no request while stopped", dut_pulses, 0);
    wr(4'h0, 16'hCCCC);
    // R9 period (3+1)*4 ticks, tick every cycle
    measure("R9 period div4", 16);
    // R6 sticky: other keys do not stop it
    wr(4'h0, 16'h0000);
    measure("R6 still running", 16);
    // R7 refresh every 10 cycles prevents expiry
    dut_pulses = 0;
    for (int i = 0; i < 20; i++) begin
      wr(4'h0, 16'hAAAA);
      idle(8);
    end
    check("R7 refresh holds off reset", dut_pulses, 0);
    // R8 slower tick pattern
    tick_mode = 2;
    measure("R8 period one tick in three", 48);
    tick_mode = 1;
    // R8 code 7 divides by 256, reload 1
    wr(4'h0, 16'h5555);
    wr(4'h4, 16'h0007);
    wr(4'h0, 16'h5555);
    wr(4'h8, 16'h0001);
    idle(6);
    rd("R10 status bits", 4'hC, 0);
    measure("R8 code7 period", 512);
    // R8 code 6 also 256? no: code 6 is 256 too, code 5 is 128
    wr(4'h0, 16'h5555);
    wr(4'h4, 16'h0005);
    measure("R8 code5 period", 256);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule